// File: doc/BRIEF.md
# Parallel Printer Port Register File

This block is the byte-wide register set of a PC-style printer port. A host reaches it through an eight-location window that decodes only three address bits. Behind that window sit five registers:

- an output data latch;
- a status view of the printer lines;
- a control register;
- two plain scratch registers that carry the enhanced-port address and data bytes.

On the printer side the block drives the data bus and the control lines. It samples the status lines and the incoming data bus.

The data bus can be turned around. While the direction bit is set, the output drivers are released. A data read then captures the live pins and keeps that sample in the data latch. Writes to the control register always read back with the two top bits high. A single-cycle change pulse is given only when the stored value actually changes.

The acknowledge line is synchronized and watched for a falling edge. If the interrupt-enable bit is set, such an edge raises a sticky interrupt that stays up until software reads the status register.

Top module: `lpt_regfile`

## Requirements
- R1: After reset the data latch is 0x00, the control register reads 0xC0, both scratch registers read 0x00, the interrupt is low, the change pulse and read-valid are low, and the data drivers are enabled (`pd_oe` = 1).
- R2: A write to offset 0 loads the data latch, which appears on `pd_out` after the write edge. A read of offset 0 with control bit 5 clear returns the latch.
- R3: A write to offset 2 stores the written byte with bits 7 and 6 forced to 1. That value appears on `ctrl_out` and is returned by a read of offset 2.
- R4: `ctrl_chg` is high for exactly one cycle after a control write whose forced value differs from the stored one. It stays low after a control write that leaves the value unchanged.
- R5: While control bit 5 (direction) is set, `pd_oe` is 0 and a read of offset 0 returns `pd_in` and stores it in the data latch. After the direction bit is cleared, offset 0 reads that stored sample.
- R6: Offsets 3 and 4 are independent 8-bit read/write registers.
- R7: Writes to offsets 5, 6 and 7 change no register, and reads of those offsets return 0xFF.
- R8: A read of offset 1 returns `{sts_line[4:0], irq, 1'b1, 1'b0}`. The bits are, from bit 7 down: busy, acknowledge, paper out, select, error, interrupt pending, reserved (reads 1), timeout (reads 0). The `sts_line` inputs pass through one register stage.
- R9: A falling edge of `ack_n` sets `irq` within four cycles if control bit 4 is set. No interrupt is raised if bit 4 is clear.
- R10: A read of offset 1 clears `irq` after the read edge. Reads of other offsets leave it set.
- R11: If an acknowledge edge is detected in the same cycle as a status read, the interrupt stays set. The read returns the interrupt state from before that edge.
- R12: Every read (`bus_sel`=1, `bus_wr`=0) produces `bus_rvalid` high for one cycle, with the data, in the cycle after the read edge. `bus_rvalid` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| pd_out | output | 8 | Printer data bus output value |
| pd_oe | output | 1 | Printer data bus driver enable |
| pd_in | input | 8 | Printer data bus pin sample |
| ctrl_out | output | 8 | Control register driven to the printer lines |
| ctrl_chg | output | 1 | One-cycle pulse when the control value changed |
| sts_line | input | 5 | Busy, ack, paper out, select, error (bit 4 down to 0) |
| ack_n | input | 1 | Asynchronous acknowledge line, active low |
| irq | output | 1 | Interrupt request, held until a status read |

## Verification
The acknowledge edge detector and the status-read clear can both act on the interrupt flag in the same cycle. The bench provokes this by lowering `ack_n` two cycles before it issues a status read, so that the synchronized edge lands on the read edge. It then judges two things: the read must show the interrupt bit as it was before that edge, and `irq` must be high afterwards. A second status read then has to show the bit set and clear it.

// File: rtl/lpt_pkg.sv
// Shared constants for the printer port register file: register offsets,
// control bit positions and the reserved-bit mask. Assumes byte registers.
package lpt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_DATA     = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_EPP_ADDR = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_EPP_DATA = 3'd4;

    localparam int CTL_DIR_BIT    = 5;
    localparam int CTL_ACKIRQ_BIT = 4;

    localparam logic [BYTE_W-1:0] CTL_RSV_MASK = 8'hC0;
    localparam logic [BYTE_W-1:0] RD_UNUSED    = 8'hFF;
endpackage

// File: rtl/lpt_edge_sync.sv
// Synchronizes an asynchronous active-low line through STAGES flops and
// flags a falling edge of the synchronized level for one cycle.
// Assumes the line idles high; reset loads the chain with ones.
module lpt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES:0] chain;

    // Shift the pin level through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], pin_n};
    end

    // Falling edge: history high, newest synchronized level low.
    always_comb fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/lpt_irq_ctl.sv
// Sticky interrupt flag. Set by a qualified event, cleared by an
// acknowledgement; a set in the same cycle as a clear wins.
module lpt_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic irq_q
);
    // Hold the pending interrupt, set having priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_q <= 1'b0;
        else if (set_ev) irq_q <= 1'b1;
        else if (clr_ev) irq_q <= 1'b0;
    end
endmodule

// File: rtl/lpt_rd_mux.sv
// Read-data selector for the register window. Purely combinational;
// assumes the caller registers the result and handles side effects.
module lpt_rd_mux
    import lpt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data_q,
    input  logic [BYTE_W-1:0] pins_in,
    input  logic [BYTE_W-1:0] ctrl_q,
    input  logic [4:0]        sts_q,
    input  logic              irq_q,
    input  logic [BYTE_W-1:0] epp_a_q,
    input  logic [BYTE_W-1:0] epp_d_q,
    output logic [BYTE_W-1:0] value
);
    // Pick the byte addressed; unmapped offsets read all ones.
    always_comb begin
        unique case (addr)
            OFS_DATA:     value = ctrl_q[CTL_DIR_BIT] ? pins_in : data_q;
            OFS_STATUS:   value = {sts_q, irq_q, 1'b1, 1'b0};
            OFS_CTRL:     value = ctrl_q;
            OFS_EPP_ADDR: value = epp_a_q;
            OFS_EPP_DATA: value = epp_d_q;
            default:      value = RD_UNUSED;
        endcase
    end
endmodule

// File: rtl/lpt_regfile.sv
// Printer port register file: data latch with turnaround, status view,
// control register with forced reserved bits and change pulse, two
// scratch registers, and a sticky acknowledge interrupt.
// Assumes at most one bus access per cycle and registered read data.
module lpt_regfile
    import lpt_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CTRL_RESET  = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [BYTE_W-1:0] pd_out,
    output logic              pd_oe,
    input  logic [BYTE_W-1:0] pd_in,
    output logic [BYTE_W-1:0] ctrl_out,
    output logic              ctrl_chg,
    input  logic [4:0]        sts_line,
    input  logic              ack_n,
    output logic              irq
);
    logic              wr_ev, rd_ev;
    logic [BYTE_W-1:0] data_q, ctrl_q, epp_a_q, epp_d_q, ctrl_new, rd_val;
    logic [4:0]        sts_q;
    logic              chg_q, rvalid_q, ack_fall, irq_q;
    logic [BYTE_W-1:0] rdata_q;

    // Decode the access type.
    always_comb begin
        wr_ev    = bus_sel &  bus_wr;
        rd_ev    = bus_sel & ~bus_wr;
        ctrl_new = bus_wdata | CTL_RSV_MASK;
    end

    // Data latch: loaded by writes, or by reads while the bus is turned around.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (wr_ev && bus_addr == OFS_DATA)
            data_q <= bus_wdata;
        else if (rd_ev && bus_addr == OFS_DATA && ctrl_q[CTL_DIR_BIT])
            data_q <= pd_in;
    end

    // Control register: update and pulse only when the forced value differs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET | CTL_RSV_MASK;
            chg_q  <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            if (wr_ev && bus_addr == OFS_CTRL && ctrl_new != ctrl_q) begin
                ctrl_q <= ctrl_new;
                chg_q  <= 1'b1;
            end
        end
    end

    // Scratch registers for the enhanced-port address and data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epp_a_q <= '0;
            epp_d_q <= '0;
        end else if (wr_ev) begin
            if (bus_addr == OFS_EPP_ADDR) epp_a_q <= bus_wdata;
            if (bus_addr == OFS_EPP_DATA) epp_d_q <= bus_wdata;
        end
    end

    // Sample the printer status lines once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_line;
    end

    lpt_edge_sync #(.STAGES(SYNC_STAGES)) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ack_n),
        .fall  (ack_fall)
    );

    lpt_irq_ctl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (ack_fall & ctrl_q[CTL_ACKIRQ_BIT]),
        .clr_ev (rd_ev && bus_addr == OFS_STATUS),
        .irq_q  (irq_q)
    );

    lpt_rd_mux u_mux (
        .addr    (bus_addr),
        .data_q  (data_q),
        .pins_in (pd_in),
        .ctrl_q  (ctrl_q),
        .sts_q   (sts_q),
        .irq_q   (irq_q),
        .epp_a_q (epp_a_q),
        .epp_d_q (epp_d_q),
        .value   (rd_val)
    );

    // Register read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_ev;
            if (rd_ev) rdata_q <= rd_val;
        end
    end

    // Drive the outputs.
    always_comb begin
        bus_rdata  = rdata_q;
        bus_rvalid = rvalid_q;
        pd_out     = data_q;
        pd_oe      = ~ctrl_q[CTL_DIR_BIT];
        ctrl_out   = ctrl_q;
        ctrl_chg   = chg_q;
        irq        = irq_q;
    end
endmodule

// File: rtl/lpt_regfile_chk.sv
// Property checker for lpt_regfile, attached by bind below.
module lpt_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       bus_rvalid,
    input logic [7:0] ctrl_out,
    input logic       ctrl_chg,
    input logic       irq
);
    // R3: reserved control bits always read high
    p_ctrl_rsv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_out[7:6] == 2'b11);

    // R4: a change pulse follows a control write that altered the value
    p_chg_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_chg |-> ($past(bus_sel && bus_wr && bus_addr == 3'd2)
                      && ctrl_out != $past(ctrl_out)));

    // R4: the control value never moves without a change pulse
    p_ctrl_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_chg |-> $stable(ctrl_out));

    // R7: unmapped offsets read all ones
    p_unused_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr >= 3'd5) |=> bus_rdata == 8'hFF);

    // R9: an interrupt rises only while the enable bit was set
    p_irq_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctrl_out[4]));

    // R10: an interrupt drops only after a status read
    p_irq_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_sel && !bus_wr && bus_addr == 3'd1));

    // R12: each read yields exactly one valid cycle
    p_rvalid_after_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);
    p_rvalid_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_sel && !bus_wr));
endmodule

bind lpt_regfile lpt_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .ctrl_out   (ctrl_out),
    .ctrl_chg   (ctrl_chg),
    .irq        (irq)
);

// File: tb/lpt_regfile_test.sv
module lpt_regfile_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, pd_in = '0;
    logic [4:0] sts_line = 5'b10111;
    logic       ack_n = 1'b1;
    logic [7:0] bus_rdata, pd_out, ctrl_out;
    logic       bus_rvalid, pd_oe, ctrl_chg, irq;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    lpt_regfile uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
        .ctrl_out(ctrl_out), .ctrl_chg(ctrl_chg), .sts_line(sts_line),
        .ack_n(ack_n), .irq(irq)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop an expected read result whenever valid data appears (R12).
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R12 unexpected rvalid", 8'h01, 8'h00);
            end else begin
                string t = tag_q.pop_front();
                chk(t, bus_rdata, exp_q.pop_front());
            end
        end
    end

    // All tasks start and end at a falling edge.
    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_pulse();
        ack_n = 0; idle(4);
        ack_n = 1; idle(4);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        // R1 reset state
        chk("R1 pd_out", pd_out, 8'h00);
        chk("R1 ctrl_out", ctrl_out, 8'hC0);
        chk("R1 pd_oe/irq/chg/rvalid", {4'b0, pd_oe, irq, ctrl_chg, bus_rvalid}, 8'h08);
        rd(3'd3, 8'h00, "R1 epp addr reset");
        rd(3'd4, 8'h00, "R1 epp data reset");
        rd(3'd0, 8'h00, "R1 data reset");
        // R2 data latch
        wr(3'd0, 8'hA5);
        chk("R2 pd_out", pd_out, 8'hA5);
        rd(3'd0, 8'hA5, "R2 data read");
        // R3/R4 control
        wr(3'd2, 8'h13);
        chk("R3 ctrl forced", ctrl_out, 8'hD3);
        chk("R4 chg pulse", {7'b0, ctrl_chg}, 8'h01);
        idle(1);
        chk("R4 chg one cycle", {7'b0, ctrl_chg}, 8'h00);
        wr(3'd2, 8'h13);
        chk("R4 no chg same value", {7'b0, ctrl_chg}, 8'h00);
        wr(3'd2, 8'hD3);
        chk("R4 no chg forced equal", {7'b0, ctrl_chg}, 8'h00);
        rd(3'd2, 8'hD3, "R3 ctrl read");
        // R6 scratch registers
        wr(3'd3, 8'h3C);
        wr(3'd4, 8'hC3);
        rd(3'd3, 8'h3C, "R6 epp addr");
        rd(3'd4, 8'hC3, "R6 epp data");
        // R7 unmapped offsets
        for (int a = 5; a < 8; a++) wr(3'(a), 8'h00);
        for (int a = 5; a < 8; a++) rd(3'(a), 8'hFF, "R7 unused read");
        rd(3'd0, 8'hA5, "R7 data untouched");
        rd(3'd2, 8'hD3, "R7 ctrl untouched");
        rd(3'd3, 8'h3C, "R7 epp addr untouched");
        rd(3'd4, 8'hC3, "R7 epp data untouched");
        // R8 status view, interrupt idle
        rd(3'd1, 8'hBA, "R8 status");
        // R9/R10 interrupt with enable set
        ack_pulse();
        chk("R9 irq set", {7'b0, irq}, 8'h01);
        rd(3'd0, 8'hA5, "R10 other read");
        chk("R10 irq kept", {7'b0, irq}, 8'h01);
        rd(3'd1, 8'hBE, "R8 status irq bit");
        chk("R10 irq cleared", {7'b0, irq}, 8'h00);
        // R9 enable clear: no interrupt
        wr(3'd2, 8'h03);
        ack_pulse();
        chk("R9 no irq when disabled", {7'b0, irq}, 8'h00);
        // R11 edge detected in the same cycle as a status read
        wr(3'd2, 8'h13);
        ack_n = 0;
        idle(2);
        rd(3'd1, 8'hBA, "R11 read shows old irq");
        chk("R11 irq survives", {7'b0, irq}, 8'h01);
        ack_n = 1; idle(4);
        rd(3'd1, 8'hBE, "R11 second read");
        chk("R11 irq cleared", {7'b0, irq}, 8'h00);
        // R5 turnaround
        pd_in = 8'h5A;
        wr(3'd2, 8'h33);
        chk("R5 drivers off", {7'b0, pd_oe}, 8'h00);
        rd(3'd0, 8'h5A, "R5 pin read");
        wr(3'd2, 8'h13);
        pd_in = 8'h77;
        chk("R5 drivers on", {7'b0, pd_oe}, 8'h01);
        rd(3'd0, 8'h5A, "R5 stored sample");
        chk("R5 pd_out sample", pd_out, 8'h5A);
        idle(2);
        chk("R12 idle rvalid", {7'b0, bus_rvalid}, 8'h00);
        chk("R12 all reads seen", 8'(exp_q.size()), 8'h00);
        done = 1;
        finish_run();
    end
endmodule